// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Keyed Register Writes

This peripheral supervises software through a two-step timeout. Once enabled, a counter advances on every tick of the chosen time base, which is either the register-bus clock or a slow external clock. The external clock is synchronised and edge-detected inside the block.

When the programmable warning period elapses, a sticky expiry flag is set and the interrupt output follows it if interrupts are enabled. A second counter then times a grace period. If software does not restart the timer before that grace period ends, and the reset stage is enabled, the block drives a one-clock system reset pulse.

Software reaches the block through a simple APB-style register bus. The control and restart registers are protected. A write to either one is honoured only when a key was written just before it. The key is used up by that next protected write, whatever the result. A restart also needs its own value.

Top module: `staged_watchdog`

## Requirements
- R1: After reset, the control word (offset 0x10), the status word (0x1C) and the key-armed readback (0x18) all read 0, and both the interrupt and reset outputs are low.
- R2: Offset 0x00 reads the constant ID_VALUE (default 0x57440200), and writes to it change nothing.
- R3: Writing 0x00005AA5 to 0x18 arms the key, so 0x18 reads back 1. Writing any other value to 0x18 disarms it, so it reads back 0.
- R4: A write to 0x10 or 0x14 always disarms the key. A control write made while the key is not armed leaves the control word unchanged.
- R5: The control word keeps bits [10:0] and reads 0 above them. Bit 0 runs the timer, bit 1 selects the bus clock (1) or the external clock (0), bit 2 enables the interrupt and bit 3 enables the reset stage. Bits [7:4] hold the warning code and bits [10:8] hold the grace code.
- R6: The warning period is 2^E ticks. E is 6, 8 or 10 for codes 0 to 2, code+8 for codes 3 to 7, and 17+2*(code-8) for codes 8 to 15. The flag rises exactly 2^E ticks after the timer is enabled or restarted.
- R7: Status bit 0 stays set until a write with bit 0 = 1 to 0x1C clears it. A write with bit 0 = 0 has no effect. The interrupt output equals this flag ANDed with control bit 2.
- R8: The grace period is 2^(7+code) ticks after the warning expiry. When it ends with bit 3 set, the reset output is high for exactly one clock. With bit 3 clear, no pulse is produced.
- R9: A keyed write of 0x0000CAFE to 0x14 clears both counters and returns to the start of the warning stage, which cancels a pending grace period. A keyed restart with any other value, or a restart without the key, has no effect on the timing.
- R10: Clearing control bit 0 stops both stages and clears their counters. No expiry or reset occurs while the timer is off. Re-enabling the timer starts a full warning period.
- R11: With bit 1 clear, one tick is counted per rising edge of the external clock, seen through a two-flop synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write (1) or read (0) |
| paddr | input | ADDR_W | Byte offset of the register |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid while selected for a read |
| extClk | input | 1 | Slow external time base |
| irq | output | 1 | Warning interrupt, level |
| sysRstPulse | output | 1 | One-clock system reset request |

## Verification
Register effects appear at the clock edge that ends the access phase. The bench counts edges with its own cycle counter and stamps the edge that carried the enabling or restarting write. With the bus clock selected, the interrupt is due exactly 2^E edges after that stamp and the reset pulse exactly 2^(7+code) edges later still. The bench samples one edge before and at each due edge, and also the edge after the pulse, all at falling edges. Results that depend on the external clock are only checked against a window, because the synchroniser adds a few edges of latency.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] OFF_ID   = 8'h00;
  localparam logic [7:0] OFF_CTRL = 8'h10;
  localparam logic [7:0] OFF_KICK = 8'h14;
  localparam logic [7:0] OFF_KEY  = 8'h18;
  localparam logic [7:0] OFF_STAT = 8'h1C;

  localparam logic [31:0] KEY_VALUE  = 32'h0000_5AA5;
  localparam logic [31:0] KICK_VALUE = 32'h0000_CAFE;

  localparam int CTRL_W = 11;

  typedef enum logic {STG_WARN = 1'b0, STG_BITE = 1'b1} stage_e;

  // strobes from register control to the counting datapath
  typedef struct packed {
    logic       run;
    logic       busClk;
    logic       biteEn;
    logic [3:0] warnCode;
    logic [2:0] biteCode;
    logic       kick;
  } wdog_strobe_t;

  // warning-stage exponent: non-uniform power-of-two spacing
  function automatic logic [4:0] warnExp(input logic [3:0] code);
    if (code == 4'd0)      return 5'd6;
    else if (code == 4'd1) return 5'd8;
    else if (code == 4'd2) return 5'd10;
    else if (code < 4'd8)  return 5'(code) + 5'd8;
    else                   return 5'd17 + 5'({code[2:0], 1'b0});
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h5744_0200
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic              expireHit,
  output wdog_strobe_t      strobe,
  output logic              irq
);
  logic busWr, hitId, hitCtrl, hitKick, hitKey, hitStat, protWr, clrStat;
  logic [CTRL_W-1:0] ctrlQ;
  logic keyQ, statQ;

  assign busWr   = psel & penable & pwrite;
  assign hitId   = (paddr == ADDR_W'(OFF_ID));
  assign hitCtrl = (paddr == ADDR_W'(OFF_CTRL));
  assign hitKick = (paddr == ADDR_W'(OFF_KICK));
  assign hitKey  = (paddr == ADDR_W'(OFF_KEY));
  assign hitStat = (paddr == ADDR_W'(OFF_STAT));
  assign protWr  = busWr & (hitCtrl | hitKick);
  assign clrStat = busWr & hitStat & pwdata[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      keyQ  <= 1'b0;
      statQ <= 1'b0;
    end else begin
      if (busWr & hitKey)  keyQ <= (pwdata == DATA_W'(KEY_VALUE));
      else if (protWr)     keyQ <= 1'b0;
      if (busWr & hitCtrl & keyQ) ctrlQ <= pwdata[CTRL_W-1:0];
      if (expireHit)       statQ <= 1'b1;
      else if (clrStat)    statQ <= 1'b0;
    end
  end

  always_comb begin
    strobe.run      = ctrlQ[0];
    strobe.busClk   = ctrlQ[1];
    strobe.biteEn   = ctrlQ[3];
    strobe.warnCode = ctrlQ[7:4];
    strobe.biteCode = ctrlQ[10:8];
    strobe.kick     = busWr & hitKick & keyQ & (pwdata == DATA_W'(KICK_VALUE));
  end

  assign irq = statQ & ctrlQ[2];

  always_comb begin
    prdata = '0;
    if (psel & ~pwrite) begin
      if (hitId)        prdata = ID_VALUE;
      else if (hitCtrl) prdata = DATA_W'(ctrlQ);
      else if (hitKey)  prdata = DATA_W'(keyQ);
      else if (hitStat) prdata = DATA_W'(statQ);
    end
  end

  assert_keyConsumed_R4: assert property (@(posedge clk) disable iff (!rstN)
    protWr |=> !keyQ);
  assert_lockedCtrl_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWr & hitCtrl & !keyQ) |=> $stable(ctrlQ));
  assert_statusSticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statQ & !clrStat) |=> statQ);
endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int BITE_W      = 15,
  parameter int SYNC_STAGES = 2
)(
  input  logic         clk,
  input  logic         rstN,
  input  wdog_strobe_t strobe,
  input  logic         extClk,
  output logic         expireHit,
  output logic         biteOut
);
  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic extPrev, tick;
  stage_e stage;
  logic [CNT_W-1:0]  warnCnt, warnLimit;
  logic [BITE_W-1:0] biteCnt, biteLimit;
  logic biteQ, warnDone, biteDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      extPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_MSB-1:0], extClk};
      extPrev <= syncQ[SYNC_MSB];
    end
  end

  assign tick      = strobe.busClk | (syncQ[SYNC_MSB] & ~extPrev);
  assign warnLimit = (CNT_W'(1) << warnExp(strobe.warnCode)) - CNT_W'(1);
  assign biteLimit = (BITE_W'(1) << (5'd7 + 5'(strobe.biteCode))) - BITE_W'(1);
  assign warnDone  = (stage == STG_WARN) && (warnCnt == warnLimit);
  assign biteDone  = (stage == STG_BITE) && (biteCnt == biteLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage   <= STG_WARN;
      warnCnt <= '0;
      biteCnt <= '0;
      biteQ   <= 1'b0;
    end else if (!strobe.run) begin
      stage   <= STG_WARN;
      warnCnt <= '0;
      biteCnt <= '0;
      biteQ   <= 1'b0;
    end else begin
      biteQ <= 1'b0;
      if (strobe.kick) begin
        stage   <= STG_WARN;
        warnCnt <= '0;
        biteCnt <= '0;
      end else if (tick) begin
        if (stage == STG_WARN) begin
          if (warnDone) begin
            warnCnt <= '0;
            biteCnt <= '0;
            stage   <= STG_BITE;
          end else begin
            warnCnt <= warnCnt + CNT_W'(1);
          end
        end else begin
          if (biteDone) begin
            biteCnt <= '0;
            stage   <= STG_WARN;
            biteQ   <= strobe.biteEn;
          end else begin
            biteCnt <= biteCnt + BITE_W'(1);
          end
        end
      end
    end
  end

  assign expireHit = strobe.run & ~strobe.kick & tick & warnDone;
  assign biteOut   = biteQ;

  assert_biteOneCycle_R8: assert property (@(posedge clk) disable iff (!rstN)
    biteQ |=> !biteQ);
  assert_biteNeedsEnable_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(biteQ) |-> $past(strobe.biteEn));
  assert_haltClears_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run |=> (warnCnt == '0 && biteCnt == '0 && stage == STG_WARN));
  assert_kickRestarts_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.run & strobe.kick) |=> (warnCnt == '0 && stage == STG_WARN));
endmodule

// File: rtl/staged_watchdog.sv
module staged_watchdog
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h5744_0200,
  parameter int CNT_W  = 32,
  parameter int BITE_W = 15
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic              extClk,
  output logic              irq,
  output logic              sysRstPulse
);
  wdog_strobe_t strobe;
  logic expireHit;

  wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_VALUE(ID_VALUE)) i_regs (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .expireHit(expireHit),
    .strobe(strobe), .irq(irq)
  );

  wdog_count #(.CNT_W(CNT_W), .BITE_W(BITE_W), .SYNC_STAGES(2)) i_count (
    .clk(clk), .rstN(rstN), .strobe(strobe), .extClk(extClk),
    .expireHit(expireHit), .biteOut(sysRstPulse)
  );
endmodule

// File: tb/test_staged_watchdog.sv
module test_staged_watchdog;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic extClk = 1'b0;
  logic irq, sysRstPulse;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int biteSeen = 0;

  localparam logic [31:0] ID = 32'h5744_0200;

  staged_watchdog i_staged_watchdog (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .extClk(extClk),
    .irq(irq), .sysRstPulse(sysRstPulse)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (sysRstPulse) biteSeen <= biteSeen + 1;
  initial forever begin
    repeat (4) @(posedge clk);
    extClk = ~extClk;
  end

  // {write, requirement, offset, data-or-expected}
  localparam int NVEC = 21;
  localparam logic [44:0] VEC [NVEC] = '{
    {1'b0, 4'd1, 8'h10, 32'h0},          // R1 control after reset
    {1'b0, 4'd1, 8'h1C, 32'h0},          // R1 status after reset
    {1'b0, 4'd1, 8'h18, 32'h0},          // R1 key not armed
    {1'b0, 4'd2, 8'h00, ID},             // R2 ID readback
    {1'b1, 4'd2, 8'h00, 32'hFFFF_FFFF},
    {1'b0, 4'd2, 8'h00, ID},             // R2 write ignored
    {1'b1, 4'd4, 8'h10, 32'h0000_07F5},  // R4 unkeyed
    {1'b0, 4'd4, 8'h10, 32'h0},
    {1'b1, 4'd3, 8'h18, 32'h0000_5AA5},  // R3 arm
    {1'b0, 4'd3, 8'h18, 32'h1},
    {1'b1, 4'd3, 8'h18, 32'h0000_1234},  // R3 disarm
    {1'b0, 4'd3, 8'h18, 32'h0},
    {1'b1, 4'd5, 8'h18, 32'h0000_5AA5},
    {1'b1, 4'd5, 8'h10, 32'hFFFF_F7F6},  // R5 field width
    {1'b0, 4'd5, 8'h10, 32'h0000_07F6},
    {1'b0, 4'd4, 8'h18, 32'h0},          // R4 key consumed
    {1'b1, 4'd4, 8'h10, 32'h0},
    {1'b0, 4'd4, 8'h10, 32'h0000_07F6},
    {1'b1, 4'd4, 8'h18, 32'h0000_5AA5},
    {1'b1, 4'd4, 8'h10, 32'h0},
    {1'b0, 4'd4, 8'h10, 32'h0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk); penable = 1'b1; d = prdata;
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  task automatic keyed(input logic [7:0] a, input logic [31:0] d);
    busWrite(8'h18, 32'h0000_5AA5);
    busWrite(a, d);
  endtask

  task automatic waitUntil(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic quiesce();
    keyed(8'h10, 32'h0);
    busWrite(8'h1C, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int s, k, c, b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 irq low", {31'b0, irq}, 32'h0);
    chk("R1 reset output low", {31'b0, sysRstPulse}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][44]) busWrite(VEC[i][39:32], VEC[i][31:0]);
      else begin
        busRead(VEC[i][39:32], rd);
        chk($sformatf("R%0d vector %0d", VEC[i][43:40], i), rd, VEC[i][31:0]);
      end
    end

    // R6 R7 R8: code 0 warning, code 0 grace
    keyed(8'h10, 32'h0000_000F); s = cyc;
    waitUntil(s + 63);  chk("R6 irq before 2^6", {31'b0, irq}, 32'h0);
    waitUntil(s + 64);  chk("R6 irq at 2^6", {31'b0, irq}, 32'h1);
    waitUntil(s + 191); chk("R8 no pulse before grace", {31'b0, sysRstPulse}, 32'h0);
    waitUntil(s + 192); chk("R8 pulse at grace end", {31'b0, sysRstPulse}, 32'h1);
    waitUntil(s + 193); chk("R8 pulse one clock", {31'b0, sysRstPulse}, 32'h0);
    busRead(8'h1C, rd); chk("R7 status set", rd, 32'h1);
    busWrite(8'h1C, 32'h0);
    busRead(8'h1C, rd); chk("R7 write 0 ignored", rd, 32'h1);
    busWrite(8'h1C, 32'h1);
    chk("R7 irq follows clear", {31'b0, irq}, 32'h0);
    busRead(8'h1C, rd); chk("R7 status cleared", rd, 32'h0);
    quiesce();

    // R6 code 1, R8 reset stage disabled
    keyed(8'h10, 32'h0000_0017); s = cyc;
    waitUntil(s + 255); chk("R6 irq before 2^8", {31'b0, irq}, 32'h0);
    waitUntil(s + 256); chk("R6 irq at 2^8", {31'b0, irq}, 32'h1);
    b0 = biteSeen;
    waitUntil(s + 400); chk("R8 no pulse when disabled", 32'(biteSeen), 32'(b0));
    quiesce();

    // R8 grace code 1
    keyed(8'h10, 32'h0000_010F); s = cyc;
    waitUntil(s + 319); chk("R8 no pulse before 2^8 grace", {31'b0, sysRstPulse}, 32'h0);
    waitUntil(s + 320); chk("R8 pulse at 2^8 grace", {31'b0, sysRstPulse}, 32'h1);
    quiesce();

    // R9 restart behaviour
    keyed(8'h10, 32'h0000_000F); s = cyc;
    waitUntil(s + 40);
    keyed(8'h14, 32'h0000_CAFE); k = cyc;
    waitUntil(k + 63); chk("R9 irq delayed by restart", {31'b0, irq}, 32'h0);
    waitUntil(k + 64); chk("R9 irq after restart", {31'b0, irq}, 32'h1);
    waitUntil(k + 100);
    keyed(8'h14, 32'h0000_CAFE); c = cyc;
    keyed(8'h14, 32'h0000_BEEF);
    busWrite(8'h14, 32'h0000_CAFE);
    b0 = biteSeen;
    waitUntil(c + 191); chk("R9 grace cancelled", 32'(biteSeen), 32'(b0));
    waitUntil(c + 192); chk("R9 bad restarts ignored", {31'b0, sysRstPulse}, 32'h1);
    quiesce();

    // R10 disable stops and clears
    keyed(8'h10, 32'h0000_000F); s = cyc;
    waitUntil(s + 100);
    quiesce(); b0 = biteSeen;
    waitUntil(cyc + 300);
    chk("R10 no pulse while off", 32'(biteSeen), 32'(b0));
    busRead(8'h1C, rd); chk("R10 no expiry while off", rd, 32'h0);
    keyed(8'h10, 32'h0000_000F); s = cyc;
    waitUntil(s + 63); chk("R10 fresh period low", {31'b0, irq}, 32'h0);
    waitUntil(s + 64); chk("R10 fresh period expiry", {31'b0, irq}, 32'h1);
    quiesce();

    // R11 external time base, one tick per 8 bus clocks
    keyed(8'h10, 32'h0000_0005); s = cyc;
    waitUntil(s + 400); chk("R11 ext clock slower", {31'b0, irq}, 32'h0);
    waitUntil(s + 600); chk("R11 ext clock expiry", {31'b0, irq}, 32'h1);
    quiesce();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule